// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between a clocked system and an external asynchronous static RAM with a 19-bit address, an 8-bit data bus and three active-low strobes (chip select, write strobe, output enable). The system side issues one word at a time: it raises a request with an address, a write flag and write data, holds them, and waits for a one-cycle acknowledge. For reads, the acknowledge comes with the returned byte.

The memory has no clock, so the controller meets its timing by counting system clock cycles. Each count comes from a nanosecond minimum and the clock period, both parameters. The quotient is rounded up to whole cycles when the design is built.

On the memory side, the address is latched one cycle before any strobe falls and is held until all strobes are high again. The write strobe pulse is stretched to cover both the minimum pulse width and the data setup time. The tri-state data driver is sequenced so that the controller and the memory never drive the shared bus at the same time. A gap with all strobes high separates consecutive operations and gives the bus time to turn around.

Top module: `asram_ctl`

## Requirements
- R1: While reset is held, chip select, write strobe and output enable are all high (inactive) and ack is low.
- R2: A write holds chip select and write strobe low together for exactly WR_CYC consecutive cycles. WR_CYC is the larger of two values: the write pulse minimum in cycles, and one plus the data setup minimum in cycles. Output enable stays high while the write strobe is low, and the write strobe is never low while chip select is high.
- R3: The data driver turns on one cycle after the write strobe falls and turns off one cycle after it rises. It is never on while output enable is low, so during a read the bus carries only the memory's byte.
- R4: The byte presented with a write request is stored at the requested address, so a later read of that address returns it.
- R5: A read holds chip select and output enable low, with the write strobe high, for exactly ACC_CYC cycles. ACC_CYC is the larger of the address-access and output-enable-access minimums in cycles. The bus value in the last of those cycles appears on rd_data, with ack, on the edge where the strobes rise.
- R6: The memory address does not change while any strobe is low.
- R7: A request is taken only when the controller is idle. Between the end of one operation and the first strobe of the next, all strobes stay high for at least TURN_CYC+2 cycles. TURN_CYC is the bus release minimum in cycles.
- R8: ack is high for exactly one cycle per operation. Write operations leave rd_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request, held until ack |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Last byte read |
| sram_addr | output | ADDR_W | Memory address |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_dq | inout | DATA_W | Shared data bus |

## Verification
The bench builds the controller with a 5000 ps clock period and the default nanosecond minimums. This gives a write pulse of 3 cycles, an access window of 3 cycles and a turnaround count of 2. Every counter therefore runs for more than one cycle, and the write pulse is set by the write pulse minimum and the data setup rule together. With multi-cycle windows, an off-by-one in a counter, a late driver turn-on or a shortened gap shows up as a wrong window length, a wrong stored byte or a short idle run. Addresses are confined to the lowest and highest 128 words, so the bench repeatedly hits the all-zero and all-one address boundaries and often reads back the same locations it wrote.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_WSTB,
      ST_WREL,
      ST_RACC,
      ST_GAP
   } asram_st_e;

   // Round a picosecond minimum up to whole clock cycles, never below one.
   function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
      int c;
      c = (t_ps + clk_ps - 1) / clk_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_dq_io.sv
module asram_dq_io #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic              drv_en,
   input  logic              cap_en,
   output logic [DATA_W-1:0] rd_data,
   inout  wire  [DATA_W-1:0] dq
);

   logic [DATA_W-1:0] wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdata_q <= '0;
         rd_data <= '0;
      end else begin
         if (load_en) wdata_q <= wdata_in;
         if (cap_en)  rd_data <= dq;
      end
   end

   // One tri-state driver per data bit, all sharing the single enable.
   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_drv
      assign dq[gi] = drv_en ? wdata_q[gi] : 1'bz;
   end

endmodule

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter int WR_CYC   = 2,
   parameter int ACC_CYC  = 2,
   parameter int TURN_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              load_en,
   output logic              cap_en,
   output logic              drv_en,
   output logic              ack,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              ce_n,
   output logic              we_n,
   output logic              oe_n
);

   localparam int CNT_MAX = imax(imax(WR_CYC, ACC_CYC), TURN_CYC);
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   asram_st_e        st;
   logic [CNT_W-1:0] cnt;
   logic             is_wr;

   assign load_en = (st == ST_IDLE) && req;
   assign cap_en  = (st == ST_RACC) && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         is_wr    <= 1'b0;
         mem_addr <= '0;
         ce_n     <= 1'b1;
         we_n     <= 1'b1;
         oe_n     <= 1'b1;
         drv_en   <= 1'b0;
         ack      <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               ack <= 1'b0;
               if (req) begin
                  mem_addr <= req_addr;
                  is_wr    <= req_wr;
                  st       <= ST_ADDR;
               end
            end
            ST_ADDR: begin
               ce_n <= 1'b0;
               if (is_wr) begin
                  we_n <= 1'b0;
                  cnt  <= CNT_W'(WR_CYC - 1);
                  st   <= ST_WSTB;
               end else begin
                  oe_n <= 1'b0;
                  cnt  <= CNT_W'(ACC_CYC - 1);
                  st   <= ST_RACC;
               end
            end
            ST_WSTB: begin
               drv_en <= 1'b1;
               if (cnt == '0) begin
                  we_n <= 1'b1;
                  ce_n <= 1'b1;
                  st   <= ST_WREL;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_WREL: begin
               drv_en <= 1'b0;
               ack    <= 1'b1;
               cnt    <= CNT_W'(TURN_CYC - 1);
               st     <= ST_GAP;
            end
            ST_RACC: begin
               if (cnt == '0) begin
                  ce_n <= 1'b1;
                  oe_n <= 1'b1;
                  ack  <= 1'b1;
                  cnt  <= CNT_W'(TURN_CYC - 1);
                  st   <= ST_GAP;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_GAP: begin
               ack <= 1'b0;
               if (cnt == '0) st  <= ST_IDLE;
               else           cnt <= cnt - 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
   import asram_pkg::*;
#(
   parameter int ADDR_W  = 19,
   parameter int DATA_W  = 8,
   parameter int CLK_PS  = 10000,
   parameter int T_WP_PS = 12000,
   parameter int T_DS_PS = 8000,
   parameter int T_AA_PS = 15000,
   parameter int T_OE_PS = 7000,
   parameter int T_HZ_PS = 7000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              ack,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_ce_n,
   output logic              sram_we_n,
   output logic              sram_oe_n,
   inout  wire  [DATA_W-1:0] sram_dq
);

   localparam int WP_CYC   = ps_to_cyc(T_WP_PS, CLK_PS);
   localparam int DS_CYC   = ps_to_cyc(T_DS_PS, CLK_PS);
   localparam int WR_CYC   = imax(WP_CYC, DS_CYC + 1);
   localparam int ACC_CYC  = imax(ps_to_cyc(T_AA_PS, CLK_PS), ps_to_cyc(T_OE_PS, CLK_PS));
   localparam int TURN_CYC = ps_to_cyc(T_HZ_PS, CLK_PS);

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("asram_ctl: address and data widths must be at least one bit");
   end
   if (CLK_PS < 1) begin : g_bad_clk
      $error("asram_ctl: clock period must be positive");
   end
   if (WR_CYC < 2) begin : g_bad_wr
      $error("asram_ctl: write pulse must span at least two cycles");
   end

   logic load_en;
   logic cap_en;
   logic drv_en;

   asram_seq #(
      .ADDR_W  (ADDR_W),
      .WR_CYC  (WR_CYC),
      .ACC_CYC (ACC_CYC),
      .TURN_CYC(TURN_CYC)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .req_wr  (req_wr),
      .req_addr(req_addr),
      .load_en (load_en),
      .cap_en  (cap_en),
      .drv_en  (drv_en),
      .ack     (ack),
      .mem_addr(sram_addr),
      .ce_n    (sram_ce_n),
      .we_n    (sram_we_n),
      .oe_n    (sram_oe_n)
   );

   asram_dq_io #(
      .DATA_W(DATA_W)
   ) u_io (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (load_en),
      .wdata_in(req_wdata),
      .drv_en  (drv_en),
      .cap_en  (cap_en),
      .rd_data (rd_data),
      .dq      (sram_dq)
   );

endmodule

// File: rtl/asram_ctl_chk.sv
module asram_ctl_chk #(
   parameter int ADDR_W = 19
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              we_n,
   input logic              oe_n,
   input logic              drv_en,
   input logic              ack,
   input logic [ADDR_W-1:0] addr
);

   p_oe_high_in_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> oe_n);

   p_we_needs_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> !ce_n);

   p_drv_after_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_n) |=> drv_en);

   p_drv_off_after_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |=> !drv_en);

   p_no_drv_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> !drv_en);

   p_addr_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && $past(!ce_n)) |-> $stable(addr));

   p_ack_strobes_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (ce_n && we_n && oe_n));

   p_ack_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

endmodule

bind asram_ctl asram_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .ce_n  (sram_ce_n),
   .we_n  (sram_we_n),
   .oe_n  (sram_oe_n),
   .drv_en(drv_en),
   .ack   (ack),
   .addr  (sram_addr)
);

// File: tb/asram_ctl_tb.sv
`timescale 1ns/1ps
module asram_ctl_tb;

   localparam int AW     = 19;
   localparam int DW     = 8;
   localparam int CLK_PS = 5000;

   function automatic int cyc(input int t_ps);
      int c;
      c = (t_ps + CLK_PS - 1) / CLK_PS;
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int EXP_WR   = mx(cyc(12000), cyc(8000) + 1);
   localparam int EXP_ACC  = mx(cyc(15000), cyc(7000));
   localparam int EXP_TURN = cyc(7000);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic          req_wr = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          ack;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] sram_addr;
   logic          sram_ce_n, sram_we_n, sram_oe_n;
   wire  [DW-1:0] sram_dq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   asram_ctl #(.CLK_PS(CLK_PS)) u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
      .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rd_data(rd_data),
      .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
      .sram_oe_n(sram_oe_n), .sram_dq(sram_dq)
   );

   // Memory model over a folded index: addresses used are the 128 lowest and 128 highest words.
   function automatic logic [7:0] fold(input logic [AW-1:0] a);
      return {a[AW-1], a[6:0]};
   endfunction
   function automatic logic [DW-1:0] dflt(input logic [7:0] i);
      return i ^ 8'h3C;
   endfunction

   logic [DW-1:0] mdl_mem [256];
   logic [DW-1:0] exp_mem [256];
   logic [DW-1:0] mdl_q;
   assign mdl_q   = mdl_mem[fold(sram_addr)];
   assign sram_dq = (!sram_ce_n && !sram_oe_n && sram_we_n) ? mdl_q : 'z;

   task automatic check(input bit ok, input string req_tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req_tag, act, exp, $time);
      end
   endtask

   // Port monitor, sampled on the falling edge.
   int            we_run = 0, oe_run = 0, hi_run = 0;
   bit            seen_op = 1'b0, wr_act = 1'b0, prev_any_low = 1'b0, prev_ack = 1'b0;
   logic [AW-1:0] prev_addr = '0;
   logic [DW-1:0] last_dq = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         bit any_low;
         any_low = !sram_ce_n || !sram_we_n || !sram_oe_n;
         if (!sram_we_n) check(sram_oe_n && !sram_ce_n, "R2 strobe mix", {sram_ce_n, sram_oe_n}, 2'b01);
         if (any_low && prev_any_low) check(sram_addr == prev_addr, "R6 address moved", sram_addr, prev_addr);
         if (!sram_we_n) we_run++;
         else if (we_run != 0) begin
            check(we_run == EXP_WR, "R2 write pulse length", we_run, EXP_WR);
            we_run = 0;
         end
         if (!sram_oe_n) begin
            check(sram_we_n, "R5 write strobe during read", sram_we_n, 1);
            oe_run++;
         end else if (oe_run != 0) begin
            check(oe_run == EXP_ACC, "R5 access window length", oe_run, EXP_ACC);
            oe_run = 0;
         end
         if (!any_low) hi_run++;
         else begin
            if (hi_run != 0 && seen_op)
               check(hi_run >= EXP_TURN + 2, "R7 idle gap", hi_run, EXP_TURN + 2);
            hi_run = 0;
            seen_op = 1'b1;
         end
         if (!sram_ce_n && !sram_we_n) begin
            last_dq = sram_dq;
            wr_act = 1'b1;
         end else if (wr_act) begin
            mdl_mem[fold(prev_addr)] = last_dq;
            wr_act = 1'b0;
         end
         if (ack && prev_ack) check(1'b0, "R8 ack longer than one cycle", 1, 0);
         prev_any_low = any_low;
         prev_addr = sram_addr;
         prev_ack = ack;
      end
   end

   logic [DW-1:0] last_rd = '0;

   task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
      int t;
      req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
      t = 0;
      do begin
         @(negedge clk);
         t++;
      end while (!ack && t < 100);
      req = 1'b0;
      check(ack, "R8 ack missing", 0, 1);
      if (wr) begin
         exp_mem[fold(a)] = d;
         check(rd_data == last_rd, "R8 rd_data after write", rd_data, last_rd);
      end else begin
         check(rd_data == exp_mem[fold(a)], "R4 R5 R3 read data", rd_data, exp_mem[fold(a)]);
         last_rd = rd_data;
      end
   endtask

   function automatic logic [AW-1:0] pick_addr(input int unsigned r);
      return (r[7] ? 19'h7FF80 : 19'h00000) | AW'(r[6:0]);
   endfunction

   initial begin
      for (int i = 0; i < 256; i++) begin
         mdl_mem[i] = dflt(8'(i));
         exp_mem[i] = dflt(8'(i));
      end
      void'($urandom(32'd1234));
      repeat (3) begin
         @(negedge clk);
         check(sram_ce_n && sram_we_n && sram_oe_n && !ack, "R1 reset state",
               {sram_ce_n, sram_we_n, sram_oe_n, ack}, 4'b1110);
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // Directed corners: address extremes, unwritten read, back-to-back same address.
      do_op(1'b1, 19'h00000, 8'h5A);
      do_op(1'b1, 19'h7FFFF, 8'hA5);
      do_op(1'b0, 19'h7FFFF, 8'h00);
      do_op(1'b0, 19'h00000, 8'h00);
      do_op(1'b0, 19'h00005, 8'h00);
      do_op(1'b1, 19'h00011, 8'hFF);
      do_op(1'b0, 19'h00011, 8'h00);
      do_op(1'b1, 19'h00011, 8'h00);
      do_op(1'b0, 19'h00011, 8'h00);
      for (int k = 0; k < 400; k++) begin
         int unsigned r;
         r = $urandom;
         do_op(r[20], pick_addr(r), 8'(r >> 8));
         repeat (r[25:24]) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule